// File: doc/BRIEF.md
# Clock Synthesizer Scan-Chain Reconfiguration Sequencer

This block rewrites the divider and loop-filter settings of an on-chip clock synthesizer. The synthesizer holds these settings in a 144-bit serial scan chain. The host places the new setting word on a parallel input and pulses a start strobe. The sequencer first opens the scan-clock enable for one idle lead-in cycle. It then shifts the word out least significant bit first and closes the enable after the last bit. A one-cycle update strobe follows, which loads the chain into the synthesizer counters.

After the update, the synthesizer raises its done handshake while it reconfigures, and drops it once the new settings are in force. The sequencer waits for that rise and then for that fall. If the host flagged that the change touches settings which need a restart, the sequencer then holds the synthesizer reset for a fixed number of cycles. It finishes with a one-cycle complete pulse and returns to idle, ready for another run. A missing rise or a missing fall ends the run with a one-cycle timeout pulse. Every part of the block runs on the scan clock.

The states are IDLE, LEAD, SHIFT, UPDATE, WAIT_RISE, WAIT_FALL, PLL_RST, FINISH and FAULT. They are connected by these transitions:
- IDLE→LEAD on start, which also latches the word and the restart flag.
- LEAD→SHIFT unconditionally.
- SHIFT→UPDATE when the bit index reaches 143.
- UPDATE→WAIT_RISE unconditionally.
- WAIT_RISE→WAIT_FALL when done is high.
- WAIT_FALL→PLL_RST when done is low and a restart was requested.
- WAIT_FALL→FINISH when done is low and no restart was requested.
- PLL_RST→FINISH after the reset width.
- WAIT_RISE→FAULT or WAIT_FALL→FAULT when the timeout window expires.
- FINISH→IDLE and FAULT→IDLE unconditionally.

Top module: `pll_scan_seq`

## Requirements
- R1: The word presented with start is captured on that clock. Exactly CHAIN_LEN (144) bits are shifted, bit 0 first and bit 143 last, and later changes of the word input have no effect on the run.
- R2: scan_en rises one cycle before bit 0 is presented. The first rising edge with scan_en high is a lead-in edge that carries no data, so scan_en stays high for exactly CHAIN_LEN+1 consecutive rising edges.
- R3: scan_en goes low right after the edge that samples bit 143, so no stray bit enters the chain.
- R4: cfg_update is high for exactly one cycle, in the cycle directly after scan_en falls.
- R5: complete is a one-cycle pulse. It is given only after scan_done has risen and then fallen, and never while scan_done is high.
- R6: When need_reset was high at start, pll_reset is high for exactly RST_CYCLES consecutive cycles, after scan_done falls and before complete. When need_reset was low, pll_reset stays low.
- R7: busy is high from the cycle after start until the sequencer is back in IDLE. A start pulse while busy is ignored.
- R8: If scan_done does not rise within DONE_TIMEOUT cycles of entering WAIT_RISE, timeout_err pulses for one cycle DONE_TIMEOUT+1 cycles after the cfg_update cycle. No complete and no reset are given, and the block returns to idle.
- R9: If scan_done rises but does not fall within DONE_TIMEOUT cycles, timeout_err pulses for one cycle with no complete and no reset, and the block returns to idle.
- R10: After reset all outputs are low. The sequence can be run again any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a reconfiguration |
| cfg_word | input | 144 | Setting word, bit 0 shifted first |
| need_reset | input | 1 | Request a synthesizer reset after the update takes effect |
| scan_done | input | 1 | Done handshake from the synthesizer |
| scan_en | output | 1 | Scan-clock enable to the chain |
| scan_data | output | 1 | Serial data to the chain |
| cfg_update | output | 1 | One-cycle commit strobe |
| pll_reset | output | 1 | Reset pulse to the synthesizer |
| busy | output | 1 | Sequence in progress |
| complete | output | 1 | One-cycle end-of-sequence pulse |
| timeout_err | output | 1 | One-cycle pulse when the done handshake times out |

## Verification
The bench keeps the full 144-bit chain length, so the lead-in edge and the last-bit boundary are exercised at the real width. It sets RST_CYCLES to 3, which shows that the pulse width follows the parameter and not the default. It sets DONE_TIMEOUT to 40 so that both the never-rises and the never-falls timeouts fire within a few dozen cycles. A behavioural chain model answers each update with a delayed done pulse that is well inside that window.

// File: rtl/pll_scan_pkg.sv
package pll_scan_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_UPDATE,
        ST_WAIT_RISE,
        ST_WAIT_FALL,
        ST_PLL_RST,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/pll_scan_shifter.sv
module pll_scan_shifter #(
    parameter int CHAIN_LEN = 144
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 shift,
    input  logic [CHAIN_LEN-1:0] word,
    output logic                 sdo,
    output logic                 last
);
    localparam int IDX_W = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAIN_LEN - 1);

    logic [CHAIN_LEN-1:0] sreg;
    logic [IDX_W-1:0]     bit_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg    <= '0;
            bit_idx <= '0;
        end else if (load) begin
            sreg    <= word;
            bit_idx <= '0;
        end else if (shift) begin
            sreg    <= {1'b0, sreg[CHAIN_LEN-1:1]};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    assign sdo  = sreg[0];
    assign last = (bit_idx == LAST_IDX);

endmodule

// File: rtl/pll_scan_timer.sv
module pll_scan_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] END_VAL = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || clr) begin
            cnt <= '0;
        end else if (cnt != END_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && !clr && (cnt == END_VAL);

endmodule

// File: rtl/pll_scan_seq.sv
module pll_scan_seq
    import pll_scan_pkg::*;
#(
    parameter int CHAIN_LEN    = 144,
    parameter int RST_CYCLES   = 4,
    parameter int DONE_TIMEOUT = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CHAIN_LEN-1:0] cfg_word,
    input  logic                 need_reset,
    input  logic                 scan_done,
    output logic                 scan_en,
    output logic                 scan_data,
    output logic                 cfg_update,
    output logic                 pll_reset,
    output logic                 busy,
    output logic                 complete,
    output logic                 timeout_err
);
    seq_state_t state_q, state_d;
    logic       need_rst_q;
    logic       load_word, shift_bit, last_bit, sdo;
    logic       wait_run, wait_clr, wait_expired;
    logic       rst_run, rst_expired;

    // Serial chain driver: word register plus bit index
    pll_scan_shifter #(.CHAIN_LEN(CHAIN_LEN)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_word),
        .shift (shift_bit),
        .word  (cfg_word),
        .sdo   (sdo),
        .last  (last_bit)
    );

    // Handshake watchdog, restarted between the rise and the fall phases
    pll_scan_timer #(.LIMIT(DONE_TIMEOUT)) u_wait_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .clr     (wait_clr),
        .expired (wait_expired)
    );

    // Synthesizer reset pulse width
    pll_scan_timer #(.LIMIT(RST_CYCLES)) u_rst_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (rst_run),
        .clr     (1'b0),
        .expired (rst_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            need_rst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                need_rst_q <= need_reset;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_LEAD;
            ST_LEAD:      state_d = ST_SHIFT;
            ST_SHIFT:     if (last_bit) state_d = ST_UPDATE;
            ST_UPDATE:    state_d = ST_WAIT_RISE;
            ST_WAIT_RISE: begin
                if (scan_done)         state_d = ST_WAIT_FALL;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_WAIT_FALL: begin
                if (!scan_done)        state_d = need_rst_q ? ST_PLL_RST : ST_FINISH;
                else if (wait_expired) state_d = ST_FAULT;
            end
            ST_PLL_RST:   if (rst_expired) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_word   = (state_q == ST_IDLE) && start;
        shift_bit   = (state_q == ST_SHIFT);
        wait_run    = (state_q == ST_WAIT_RISE) || (state_q == ST_WAIT_FALL);
        wait_clr    = (state_q == ST_WAIT_RISE) && scan_done;
        rst_run     = (state_q == ST_PLL_RST);
        scan_en     = (state_q == ST_LEAD) || (state_q == ST_SHIFT);
        scan_data   = (state_q == ST_SHIFT) && sdo;
        cfg_update  = (state_q == ST_UPDATE);
        pll_reset   = (state_q == ST_PLL_RST);
        busy        = (state_q != ST_IDLE);
        complete    = (state_q == ST_FINISH);
        timeout_err = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/pll_scan_chk.sv
module pll_scan_chk (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic cfg_update,
    input logic pll_reset,
    input logic scan_done,
    input logic busy,
    input logic complete,
    input logic timeout_err
);
    assert_lead_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |=> scan_en);

    assert_update_follows_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> cfg_update);

    assert_enable_low_at_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |-> !scan_en);

    assert_update_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

    assert_complete_done_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        complete |-> !scan_done);

    assert_complete_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> !complete);

    assert_reset_isolated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset |-> !scan_en && !cfg_update && !complete);

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scan_en && !cfg_update && !pll_reset && !complete && !timeout_err);

    assert_fault_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> !complete && !pll_reset);

    assert_fault_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !busy);

endmodule

bind pll_scan_seq pll_scan_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .cfg_update  (cfg_update),
    .pll_reset   (pll_reset),
    .scan_done   (scan_done),
    .busy        (busy),
    .complete    (complete),
    .timeout_err (timeout_err)
);

// File: tb/sim_pll_scan_seq.sv
`timescale 1ns/1ps
module sim_pll_scan_seq;
    localparam int N    = 144;
    localparam int RSTW = 3;
    localparam int TMO  = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] cfg_word = '0;
    logic         need_reset = 1'b0;
    logic         scan_done = 1'b0;
    logic         scan_en, scan_data, cfg_update, pll_reset, busy, complete, timeout_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pll_scan_seq #(.CHAIN_LEN(N), .RST_CYCLES(RSTW), .DONE_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word),
        .need_reset(need_reset), .scan_done(scan_done), .scan_en(scan_en),
        .scan_data(scan_data), .cfg_update(cfg_update), .pll_reset(pll_reset),
        .busy(busy), .complete(complete), .timeout_err(timeout_err)
    );

    // Behavioural chain responder. Modes: 0 normal, 1 done never rises, 2 done never falls
    int           resp_mode = 0;
    logic         lead_seen = 1'b0;
    logic [N-1:0] cap = '0;
    int           nbits = 0;
    int           en_edges = 0;
    int           dly = -1;
    int           hold = 0;
    logic         fall_seen = 1'b0;
    logic         rise_seen = 1'b0;

    always @(posedge clk) begin
        if (scan_en) begin
            if (!lead_seen) begin
                lead_seen <= 1'b1;
                en_edges  <= 1;
                nbits     <= 0;
            end else begin
                cap      <= {scan_data, cap[N-1:1]};
                nbits    <= nbits + 1;
                en_edges <= en_edges + 1;
            end
        end else begin
            lead_seen <= 1'b0;
        end
        if (cfg_update) begin
            fall_seen <= 1'b0;
            rise_seen <= 1'b0;
            dly       <= (resp_mode == 1) ? -1 : 3;
        end else if (dly > 0) begin
            dly <= dly - 1;
        end else if (dly == 0) begin
            dly       <= -1;
            scan_done <= 1'b1;
            rise_seen <= 1'b1;
            hold      <= 5;
        end else if (scan_done && resp_mode != 2) begin
            if (hold > 1) hold <= hold - 1;
            else begin
                scan_done <= 1'b0;
                fall_seen <= 1'b1;
            end
        end else if (scan_done && !busy) begin
            scan_done <= 1'b0;
        end
    end

    // Output monitors sampled away from the active edge
    int upd_cnt = 0, cmpl_cnt = 0, err_cnt = 0, rst_cnt = 0;
    int bad_cmpl = 0, bad_rst = 0, cyc = 0, upd_cyc = 0, err_cyc = 0;
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cfg_update) begin
            upd_cnt <= upd_cnt + 1;
            upd_cyc <= cyc;
        end
        if (complete) begin
            cmpl_cnt <= cmpl_cnt + 1;
            if (scan_done || !fall_seen) bad_cmpl <= bad_cmpl + 1;
        end
        if (pll_reset) begin
            rst_cnt <= rst_cnt + 1;
            if (scan_done || !fall_seen) bad_rst <= bad_rst + 1;
        end
        if (timeout_err) begin
            err_cnt <= err_cnt + 1;
            err_cyc <= cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    int s_upd, s_cmpl, s_err, s_rst, s_bcm, s_brs;
    int busy_cycles;

    task automatic snap();
        s_upd = upd_cnt; s_cmpl = cmpl_cnt; s_err = err_cnt;
        s_rst = rst_cnt; s_bcm = bad_cmpl; s_brs = bad_rst;
    endtask

    // Launch one run; optionally disturb word and start while busy
    task automatic launch(input logic [N-1:0] w, input bit nr, input int mode, input bit poke);
        snap();
        resp_mode = mode;
        @(negedge clk);
        cfg_word = w; need_reset = nr; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cfg_word = ~w; need_reset = ~nr;
        check(busy == 1'b1, "R7 busy after start", busy, 1);
        busy_cycles = 1;
        if (poke) begin
            repeat (30) @(negedge clk);
            start = 1'b1; cfg_word = {N{1'b1}};
            @(negedge clk);
            start = 1'b0;
            busy_cycles += 31;
        end
        while (busy && busy_cycles < 2000) begin
            @(negedge clk);
            busy_cycles++;
        end
        check(!busy, "R7 return to idle", busy, 0);
        @(negedge clk);
    endtask

    task automatic test_reset_state();
        check({scan_en, scan_data, cfg_update, pll_reset, busy, complete, timeout_err} == 7'b0,
              "R10 outputs low after reset",
              {scan_en, scan_data, cfg_update, pll_reset, busy, complete, timeout_err}, 0);
    endtask

    task automatic test_normal(input logic [N-1:0] w, input bit nr, input bit poke, input string name);
        launch(w, nr, 0, poke);
        check(cap == w, {"R1 captured word ", name}, (cap == w), 1);
        check(nbits == N, {"R3 data bits ", name}, nbits, N);
        check(en_edges == N + 1, {"R2 enable edges ", name}, en_edges, N + 1);
        check(upd_cnt - s_upd == 1, {"R4 update cycles ", name}, upd_cnt - s_upd, 1);
        check(cmpl_cnt - s_cmpl == 1, {"R5 complete count ", name}, cmpl_cnt - s_cmpl, 1);
        check(bad_cmpl == s_bcm, {"R5 complete before fall ", name}, bad_cmpl - s_bcm, 0);
        check(rst_cnt - s_rst == (nr ? RSTW : 0), {"R6 reset width ", name},
              rst_cnt - s_rst, nr ? RSTW : 0);
        check(bad_rst == s_brs, {"R6 reset before fall ", name}, bad_rst - s_brs, 0);
        check(err_cnt == s_err, {"R8 no timeout ", name}, err_cnt - s_err, 0);
    endtask

    task automatic test_no_rise();
        launch({N/8{8'h5A}}, 1'b1, 1, 1'b0);
        check(err_cnt - s_err == 1, "R8 timeout pulse", err_cnt - s_err, 1);
        check(err_cyc - upd_cyc == TMO + 1, "R8 timeout delay", err_cyc - upd_cyc, TMO + 1);
        check(cmpl_cnt == s_cmpl, "R8 no complete", cmpl_cnt - s_cmpl, 0);
        check(rst_cnt == s_rst, "R8 no reset", rst_cnt - s_rst, 0);
        check(!rise_seen, "R8 done never rose", rise_seen, 0);
    endtask

    task automatic test_no_fall();
        launch({N/4{4'hC}}, 1'b1, 2, 1'b0);
        check(err_cnt - s_err == 1, "R9 timeout pulse", err_cnt - s_err, 1);
        check(cmpl_cnt == s_cmpl, "R9 no complete", cmpl_cnt - s_cmpl, 0);
        check(rst_cnt == s_rst, "R9 no reset", rst_cnt - s_rst, 0);
        check(rise_seen && !fall_seen, "R9 done rose only", {rise_seen, fall_seen}, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset_state();
        test_normal({{(N-8){1'b0}}, 8'h01}, 1'b0, 1'b0, "single low bit");
        test_normal({1'b1, {(N-1){1'b0}}}, 1'b1, 1'b0, "single high bit");
        test_normal({N/16{16'hA5C3}}, 1'b1, 1'b1, "start while busy");
        test_no_rise();
        test_no_fall();
        test_normal({N/4{4'h9}}, 1'b0, 1'b0, "R10 rerun after fault");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule